// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The block takes a wide set of level-sensitive interrupt inputs, sorts them into groups of eight and drives one output line per group. Each group line is high while at least one of that group's inputs is both pending and enabled. Input n belongs to group n/8 and occupies bit n mod 8 of that group's byte. The pending bits are a registered copy of the input levels. There is no edge capture, so a pending bit clears as soon as its source drops.

Software reaches the block through a 32-bit word-addressed register port. The first 256 bytes form 16-byte quads, and each quad serves four consecutive groups with one byte per group. Within a quad, the four words in ascending order are: enable-set (write ones to enable), enable-clear (write ones to disable), raw pending (read-only) and enabled pending (read-only). Two read-only summary words at byte offsets 0x100 and 0x104 show the state of the group lines. Every request gets a response one cycle later, carrying the read data and an error flag. Illegal accesses are reported through that flag and change nothing.

A build parameter selects external mode. In that mode, inputs of groups at or above a configured limit are ignored.

Top module: `irq_group_combiner`

## Requirements
- R1: Input n sets bit n&7 of group n>>3's pending byte on the clock edge after it is high, and clears that bit on the edge after it is low.
- R2: Group line g is high exactly when the AND of group g's enable byte and pending byte is nonzero, and it follows any change of either.
- R3: A request word address w (byte offset 4w) below 0x40 selects quad w[5:2], which serves groups 4q..4q+3, and register w[1:0]: 0 enable-set, 1 enable-clear, 2 raw pending, 3 enabled pending. Byte k of the data word, bits 8k+7:8k, belongs to group 4q+k. A read of the raw pending register returns the four pending bytes.
- R4: A write to enable-set ORs each data byte into the matching group's enable byte.
- R5: A write to enable-clear clears the enable bits where the data has ones, and leaves the other enable bits unchanged.
- R6: A read of the enabled-pending register returns, for each byte, the enable byte ANDed with the pending byte.
- R7: The word at byte offset 0x100 reads the group lines 0..31 (bit g is group g). The word at 0x104 reads groups 32..63 (bit g-32).
- R8: A write to a raw or enabled pending register, to either summary word, or to byte offset 0x108 or above responds with the error flag set and changes no state. A read at 0x108 or above responds with the error flag set and data zero.
- R9: After reset, all enable and pending bits are zero. The stored enable words at byte offsets 0xC0, 0xC4, 0xD0 and 0xD4 read 0x01010101, and every other stored enable word reads zero.
- R10: With EXT_MODE nonzero, inputs of groups with an index at or above EXT_GROUP_LIMIT never set pending bits, and those group lines stay low.
- R11: A read of an enable-set or enable-clear offset returns the full word last written to that same offset.
- R12: A request accepted while req_valid is high produces exactly one rsp_valid pulse on the next cycle, with rsp_rdata and rsp_err. Legal writes return data zero and error zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_GROUPS*8 | Level interrupt inputs |
| grp_irq | output | NUM_GROUPS | One combined line per group |
| req_valid | input | 1 | Request strobe, one per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Word address (byte offset / 4) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access was illegal |

## Verification
The bench enables a group while its input is already high, and checks that the line rises without any new input edge. A design that re-evaluated the line only on input change would leave it low. It sets enable bits in two separate writes and then clears one bit, so a design that replaced the enable byte instead of ORing it, or that cleared too many bits, shows the wrong enabled-pending word. It writes the read-only offsets and the space past the summary words, then confirms through the group lines and the status reads that nothing moved. A design that decoded those writes as enable writes would change a group line. A second instance in external mode confirms that a group above the limit stays dark while a group below it fires, and the reset readback of the four preset offsets catches a design that cleared them.

// File: rtl/irq_group_combiner.sv
module irq_group_combiner #(
  parameter int NUM_GROUPS      = 64,
  parameter int EXT_MODE        = 0,
  parameter int EXT_GROUP_LIMIT = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_GROUPS*8-1:0] irq_in,
  output logic [NUM_GROUPS-1:0]   grp_irq,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [6:0]              req_addr,
  input  logic [31:0]             req_wdata,
  output logic                    rsp_valid,
  output logic [31:0]             rsp_rdata,
  output logic                    rsp_err
);
  localparam int NIN    = NUM_GROUPS * 8;
  localparam int NQUAD  = NUM_GROUPS / 4;
  localparam int QW     = $clog2(NQUAD);
  localparam int NSTORE = 2 * NQUAD;

  logic [NIN-1:0] pend_q, mask_q, allow;
  logic [31:0]    pend_w [NQUAD];
  logic [31:0]    mask_w [NQUAD];
  logic [31:0]    en_store [NSTORE];
  logic [63:0]    grp_pad;

  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
      assign allow[8*g +: 8] = (EXT_MODE != 0 && g >= EXT_GROUP_LIMIT) ? 8'h00 : 8'hFF;
      assign grp_irq[g] = |(mask_q[8*g +: 8] & pend_q[8*g +: 8]);
    end
    for (g = 0; g < NQUAD; g++) begin : g_quad
      assign pend_w[g] = pend_q[32*g +: 32];
      assign mask_w[g] = mask_q[32*g +: 32];
    end
  endgenerate

  always_comb begin
    grp_pad = '0;
    grp_pad[NUM_GROUPS-1:0] = grp_irq;
  end

  // decode
  logic [QW-1:0] qsel;
  logic [1:0]    sel;
  logic          quad_ok, en_reg, wr_ok, rd_err;
  assign qsel    = req_addr[2 +: QW];
  assign sel     = req_addr[1:0];
  assign quad_ok = !req_addr[6] && (int'(req_addr[5:2]) < NQUAD);
  assign en_reg  = quad_ok && !sel[1];
  assign wr_ok   = req_valid && req_write && en_reg;
  assign rd_err  = req_addr >= 7'h42;

  function automatic logic [31:0] store_init(int i);
    int a;
    a = (i / 2) * 16 + (i % 2) * 4;
    return (a == 'hC0 || a == 'hC4 || a == 'hD0 || a == 'hD4) ? 32'h0101_0101 : 32'h0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      for (int i = 0; i < NSTORE; i++) en_store[i] <= store_init(i);
    end else begin
      pend_q <= irq_in & allow;
      if (wr_ok) begin
        en_store[{qsel, sel[0]}] <= req_wdata;
        for (int q = 0; q < NQUAD; q++)
          if (q == int'(qsel))
            mask_q[32*q +: 32] <= sel[0] ? (mask_q[32*q +: 32] & ~req_wdata)
                                         : (mask_q[32*q +: 32] | req_wdata);
      end
    end
  end

  logic [31:0] rd_data;
  always_comb begin
    rd_data = '0;
    if (quad_ok) begin
      case (sel)
        2'd2:    rd_data = pend_w[qsel];
        2'd3:    rd_data = mask_w[qsel] & pend_w[qsel];
        default: rd_data = en_store[{qsel, sel[0]}];
      endcase
    end else if (req_addr == 7'h40) rd_data = grp_pad[31:0];
    else if (req_addr == 7'h41)     rd_data = grp_pad[63:32];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_data : 32'h0;
      rsp_err   <= req_valid && (req_write ? !en_reg : rd_err);
    end
  end

  assert_rsp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_far_write_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr >= 7'h40) |=> rsp_err);
  assert_bad_write_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !en_reg) |=> $stable(mask_q));
  assert_set_ors_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && sel == 2'd0) |=> ((mask_w[$past(qsel)] & $past(req_wdata)) == $past(req_wdata)));
  assert_clear_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && sel == 2'd1) |=> ((mask_w[$past(qsel)] & $past(req_wdata)) == 32'h0));

  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_chk
      assert_quiet_group_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_in[8*g +: 8]) == 8'h00) |-> !grp_irq[g]);
      if (EXT_MODE != 0 && g >= EXT_GROUP_LIMIT) begin : g_ext
        assert_ext_dark_R10: assert property (@(posedge clk) disable iff (!rst_n)
          !grp_irq[g]);
      end
    end
  endgenerate
endmodule

// File: tb/irq_group_combiner_bench.sv
module irq_group_combiner_bench;
  localparam int NG = 64;
  logic clk = 0, rst_n = 0;
  logic [NG*8-1:0] irq_in = '0;
  logic [NG-1:0] grp_irq, grp_ext;
  logic req_valid = 0, req_write = 0;
  logic [6:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err, rsp_valid_x, rsp_err_x;
  logic [31:0] rsp_rdata, rsp_rdata_x;

  always #10 clk = ~clk;

  irq_group_combiner #(.NUM_GROUPS(NG)) u_irq_group_combiner (
    .clk, .rst_n, .irq_in, .grp_irq, .req_valid, .req_write, .req_addr,
    .req_wdata, .rsp_valid, .rsp_rdata, .rsp_err);

  irq_group_combiner #(.NUM_GROUPS(NG), .EXT_MODE(1), .EXT_GROUP_LIMIT(4)) u_irq_group_combiner_ext (
    .clk, .rst_n, .irq_in, .grp_irq(grp_ext), .req_valid, .req_write, .req_addr,
    .req_wdata, .rsp_valid(rsp_valid_x), .rsp_rdata(rsp_rdata_x), .rsp_err(rsp_err_x));

  int checks = 0, fails = 0, cycles = 0;
  logic [32:0] exp_q[$];
  string tag_q[$];

  task automatic chk(input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (exp_q.size() == 0) chk("R12 unexpected response", 33'h1, 33'h0);
    else chk(tag_q.pop_front(), {rsp_err, rsp_rdata}, exp_q.pop_front());
  end

  task automatic xfer(input bit wr, input int byte_addr, input logic [31:0] d,
                      input logic [31:0] exp_d, input bit exp_e, input string tag);
    req_valid = 1; req_write = wr; req_addr = 7'(byte_addr >> 2); req_wdata = d;
    exp_q.push_back({exp_e, exp_d}); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
  endtask

  task automatic rd(input int a, input logic [31:0] e, input bit ee, input string tag);
    xfer(0, a, 0, e, ee, tag);
  endtask
  task automatic wr(input int a, input logic [31:0] d, input bit ee, input string tag);
    xfer(1, a, d, 0, ee, tag);
  endtask
  task automatic line(input string tag, input logic act, input logic exp);
    chk(tag, {32'h0, act}, {32'h0, exp});
  endtask
  task automatic drive(input int n, input logic v);
    irq_in[n] = v;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 lines after reset", {1'b0, grp_irq[31:0]}, 33'h0);
    rd('hC0, 32'h01010101, 0, "R9 preset C0");
    rd('hC4, 32'h01010101, 0, "R9 preset C4");
    rd('hD0, 32'h01010101, 0, "R9 preset D0");
    rd('hD4, 32'h01010101, 0, "R9 preset D4");
    rd('h00, 32'h0, 0, "R9 other word zero");
    rd('hC8, 32'h0, 0, "R9 pending zero");

    drive(3, 1); drive(13, 1);
    rd('h08, 32'h00002008, 0, "R1 R3 raw pending bytes");
    line("R2 disabled group low", grp_irq[0], 0);
    rd('h0C, 32'h0, 0, "R6 masked with no enable");

    wr('h00, 32'h00000008, 0, "R12 legal write");
    line("R2 line rises on enable", grp_irq[0], 1);
    line("R2 other group low", grp_irq[1], 0);
    rd('h0C, 32'h00000008, 0, "R6 masked one group");
    rd('h100, 32'h00000001, 0, "R7 summary low word");
    rd('h00, 32'h00000008, 0, "R11 set readback");

    wr('h00, 32'h00002000, 0, "R4 second set");
    rd('h0C, 32'h00002008, 0, "R4 set ORs");
    rd('h00, 32'h00002000, 0, "R11 last set word");

    wr('h04, 32'h00000008, 0, "R5 clear");
    line("R5 cleared group low", grp_irq[0], 0);
    line("R5 other group kept", grp_irq[1], 1);
    rd('h0C, 32'h00002000, 0, "R5 masked after clear");
    rd('h04, 32'h00000008, 0, "R11 clear readback");

    drive(13, 0);
    line("R1 input drop lowers line", grp_irq[1], 0);
    rd('h08, 32'h00000008, 0, "R1 pending follows level");

    drive(40*8+1, 1); drive(17, 1);
    wr('hA0, 32'h00000002, 0, "R3 high quad set");
    wr('h00, 32'h00020000, 0, "R3 byte two set");
    rd('h104, 32'h00000100, 0, "R7 summary high word");
    rd('h100, 32'h00000004, 0, "R7 summary group two");
    rd('hA8, 32'h00000002, 0, "R3 high quad raw");
    line("R10 ext group above limit dark", grp_ext[40], 0);
    line("R10 ext group below limit fires", grp_ext[2], 1);
    line("R10 normal instance group 40", grp_irq[40], 1);

    wr('h0C, 32'hFFFFFFFF, 1, "R8 write masked status");
    wr('h08, 32'hFFFFFFFF, 1, "R8 write raw status");
    wr('h100, 32'hFFFFFFFF, 1, "R8 write summary");
    wr('h108, 32'hFFFFFFFF, 1, "R8 write past end");
    line("R8 illegal writes inert", grp_irq[0], 0);
    rd('h0C, 32'h00020000, 0, "R8 masked unchanged");
    rd('h10C, 32'h0, 1, "R8 read past end");

    repeat (3) @(negedge clk);
    chk("R12 all responses seen", {1'b0, 32'(exp_q.size())}, 33'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule